// File: doc/BRIEF.md
# Masked interrupt level encoder

This block collects thirteen level-sensitive interrupt lines from board peripherals and turns them into one 4-bit interrupt level for the processor. Each line sets its own bit in a 16-bit status word while it is high. The status word is ANDed with a software mask. Among the sources left, the one with the lowest priority code wins. The 4-bit output is the winning code XORed with 15, so a quiet board drives 0 and the most urgent source drives 15.

A small 16-bit register port sits beside the encoder, within a 64-byte window. It holds:
- the mask;
- a general-purpose output register that drives pins;
- a fixed version word;
- a power-off control that produces a one-cycle shutdown request.

Top module: `irq_level_ctrl`

## Requirements
- R1: After synchronous reset, the mask and the output-port register are zero, `irl_o` is 0, `rdata_o` is 0 and `shutdown_o` is low.
- R2: Source line `src_i[k]` has priority code k (0 is most urgent). Its status and mask bit is, for k = 0..12 in turn: 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15. Status bits 1 to 3 never become set.
- R3: The level is the smallest code among sources that are high and unmasked, or 15 if there are none. `irl_o` equals that level XOR 15, so `irl_o` is 0 with no active unmasked source.
- R4: A source whose mask bit (position from R2) is 0 does not affect `irl_o`.
- R5: `irl_o` is registered. It reflects a source change, or a mask write, on the first rising clock edge at which that change is present.
- R6: A status bit follows its source level. When a line drops, its source stops contributing at the next edge.
- R7: Offset 0x00 is the mask register. Writes store all 16 bits, and reads return the stored value. Read data appears on `rdata_o` one cycle after a read request (`req_i`=1, `we_i`=0) and is 0 in cycles without a read.
- R8: Offset 0x36 is the output-port register. Writes store the data, reads return it, and `gpo_o` always shows it.
- R9: Offset 0x30 reads as 0. A write there with data bit 0 set raises `shutdown_o` for exactly one cycle, after the write's edge. A write with bit 0 clear does not raise it.
- R10: Offset 0x32 reads as 0x0010, and writes to it change nothing.
- R11: Any other offset reads as 0. Writes to it leave the mask and the output-port register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 13 | Interrupt source lines, index = priority code |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 6 | Byte offset in the register window |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irl_o | output | 4 | Encoded interrupt level (code XOR 15) |
| gpo_o | output | 16 | General-purpose output register |
| shutdown_o | output | 1 | One-cycle power-off request |

## Verification
The encoder is first driven with one source at a time under a full mask, which confirms every code and its bit position. It is then driven with several sources at once, which shows that the smallest code wins and not the highest bit or the highest index. Partial and empty masks then show that a masked urgent source gives way to a less urgent unmasked one, and that an empty mask forces 0. Separate timing checks sample one edge after a source change, after a source drop and after a mask write, which distinguishes the registered output from a two-stage path.

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
  parameter logic [15:0] VERSION_ID = 16'h0010
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [12:0] src_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [5:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic [3:0]  irl_o,
  output logic [15:0] gpo_o,
  output logic        shutdown_o
);
  localparam int          NSRC     = 13;
  localparam logic [5:0]  OFF_MASK = 6'h00;
  localparam logic [5:0]  OFF_PWR  = 6'h30;
  localparam logic [5:0]  OFF_VER  = 6'h32;
  localparam logic [5:0]  OFF_GPO  = 6'h36;

  function automatic int bitpos(input int k);
    case (k)
      0: return 11;   1: return 9;    2: return 8;    3: return 12;
      4: return 10;   5: return 6;    6: return 5;    7: return 4;
      8: return 7;    9: return 14;   10: return 13;  11: return 0;
      default: return 15;
    endcase
  endfunction

  logic [15:0] mask_q, mask_d, stat_q, stat_d, gpo_q, rd_mux, pend;
  logic [3:0]  lvl, irl_q;
  logic [15:0] rdata_q;
  logic        shut_q;

  wire wr = req_i & we_i;
  wire rd = req_i & ~we_i;

  assign mask_d = (wr && addr_i == OFF_MASK) ? wdata_i : mask_q;

  always_comb begin
    stat_d = '0;
    for (int k = 0; k < NSRC; k++) stat_d[bitpos(k)] = src_i[k];
  end

  assign pend = stat_d & mask_d;

  always_comb begin
    lvl = 4'hF;
    for (int k = NSRC - 1; k >= 0; k--)
      if (pend[bitpos(k)]) lvl = 4'(k);
  end

  always_comb begin
    case (addr_i)
      OFF_MASK: rd_mux = mask_q;
      OFF_GPO:  rd_mux = gpo_q;
      OFF_VER:  rd_mux = VERSION_ID;
      default:  rd_mux = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      stat_q  <= '0;
      gpo_q   <= '0;
      irl_q   <= '0;
      rdata_q <= '0;
      shut_q  <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      stat_q  <= stat_d;
      if (wr && addr_i == OFF_GPO) gpo_q <= wdata_i;
      irl_q   <= lvl ^ 4'hF;
      rdata_q <= rd ? rd_mux : 16'h0000;
      shut_q  <= wr && addr_i == OFF_PWR && wdata_i[0];
    end
  end

  assign rdata_o    = rdata_q;
  assign irl_o      = irl_q;
  assign gpo_o      = gpo_q;
  assign shutdown_o = shut_q;

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (src_i == '0) |=> (irl_o == 4'h0));

  a_r2_no_low_status: assert property (@(posedge clk) disable iff (rst)
    stat_q[3:1] == 3'b000);

  a_r4_empty_mask_zero: assert property (@(posedge clk) disable iff (rst)
    (mask_d == '0) |=> (irl_o == 4'h0));

  a_r9_pulse_source: assert property (@(posedge clk) disable iff (rst)
    $rose(shutdown_o) |-> $past(req_i && we_i && addr_i == OFF_PWR && wdata_i[0]));

  a_r10_version_read: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(req_i && !we_i && addr_i == OFF_VER)) |-> rdata_o == VERSION_ID);

  a_r8_gpo_hold: assert property (@(posedge clk) disable iff (rst)
    !(req_i && we_i && addr_i == OFF_GPO) |=> $stable(gpo_o));

  a_r7_idle_rdata: assert property (@(posedge clk) disable iff (rst)
    !(req_i && !we_i) |=> rdata_o == 16'h0000);
endmodule

// File: tb/test_irq_level_ctrl.sv
module test_irq_level_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic [12:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, gpo;
  logic [3:0]  irl;
  logic        shutdown;
  int          n_run = 0, n_fail = 0;
  logic [15:0] mask_m = '0;

  irq_level_ctrl i_irq_level_ctrl (
    .clk(clk), .rst(rst), .src_i(src), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irl_o(irl), .gpo_o(gpo), .shutdown_o(shutdown)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int bp(input int k);
    int t[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
    return t[k];
  endfunction

  function automatic logic [3:0] model(input logic [12:0] s, input logic [15:0] m);
    int lv = 15;
    for (int k = 0; k < 13; k++)
      if (s[k] && m[bp(k)] && k < lv) lv = k;
    return 4'(lv) ^ 4'hF;
  endfunction

  task automatic check(input string req_tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
    if (a == 6'h00) mask_m = d;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic set_src(input logic [12:0] v);
    @(negedge clk); src = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check("R1 irl", {12'h0, irl}, 16'h0);
    check("R1 gpo", gpo, 16'h0);
    check("R1 shutdown", {15'h0, shutdown}, 16'h0);
    check("R1 rdata", rdata, 16'h0);
    bus_read(6'h00, d);
    check("R1 mask", d, 16'h0);
  endtask

  task automatic t_single;
    bus_write(6'h00, 16'hFFFF);
    for (int k = 0; k < 13; k++) begin
      set_src(13'(1) << k);
      check("R2 single source", {12'h0, irl}, {12'h0, 4'(k) ^ 4'hF});
    end
  endtask

  task automatic t_multi;
    set_src('1);
    check("R3 all sources", {12'h0, irl}, 16'h000F);
    set_src(13'b1_0010_0000_0000);
    check("R3 code 9 vs 12", {12'h0, irl}, 16'h0006);
    set_src(13'b0_1000_0010_1000);
    check("R3 code 3 vs 5,11", {12'h0, irl}, {12'h0, model(src, mask_m)});
    set_src('0);
    check("R6 drop to idle", {12'h0, irl}, 16'h0);
  endtask

  task automatic t_mask;
    set_src('1);
    bus_write(6'h00, 16'h0040);
    check("R4 only code 5 unmasked", {12'h0, irl}, 16'h000A);
    bus_write(6'h00, 16'h000E);
    check("R4 unused bits only", {12'h0, irl}, 16'h0);
    bus_write(6'h00, 16'h0000);
    check("R4 empty mask", {12'h0, irl}, 16'h0);
    bus_write(6'h00, 16'hA0A1);
    check("R4 partial mask", {12'h0, irl}, {12'h0, model(src, mask_m)});
  endtask

  task automatic t_timing;
    bus_write(6'h00, 16'hFFFF);
    set_src('0);
    @(negedge clk); src = 13'h0010;
    @(posedge clk); #1;
    check("R5 one edge after source", {12'h0, irl}, 16'h000B);
    @(negedge clk); src = 13'h0011;
    @(posedge clk); #1;
    check("R5 higher source", {12'h0, irl}, 16'h000F);
    @(negedge clk); src = 13'h0010;
    @(posedge clk); #1;
    check("R6 drop of winner", {12'h0, irl}, 16'h000B);
    @(negedge clk); req = 1; we = 1; addr = 6'h00; wdata = 16'h0000;
    @(posedge clk); #1; req = 0; we = 0; mask_m = 16'h0;
    check("R5 mask write edge", {12'h0, irl}, 16'h0);
    set_src('0);
  endtask

  task automatic t_regs;
    logic [15:0] d;
    bus_write(6'h00, 16'hA5C3);
    bus_read(6'h00, d);
    check("R7 mask readback", d, 16'hA5C3);
    @(negedge clk);
    check("R7 idle rdata", rdata, 16'h0);
    bus_write(6'h36, 16'h1234);
    check("R8 gpo pins", gpo, 16'h1234);
    bus_read(6'h36, d);
    check("R8 gpo readback", d, 16'h1234);
    bus_read(6'h32, d);
    check("R10 version", d, 16'h0010);
    bus_write(6'h32, 16'hFFFF);
    bus_read(6'h32, d);
    check("R10 version after write", d, 16'h0010);
    bus_read(6'h30, d);
    check("R9 power reads zero", d, 16'h0);
    bus_write(6'h10, 16'hFFFF);
    bus_write(6'h02, 16'h5555);
    bus_read(6'h10, d);
    check("R11 other offset reads zero", d, 16'h0);
    bus_read(6'h00, d);
    check("R11 mask untouched", d, 16'hA5C3);
    check("R11 gpo untouched", gpo, 16'h1234);
  endtask

  task automatic t_power;
    @(negedge clk); req = 1; we = 1; addr = 6'h30; wdata = 16'h0002;
    @(negedge clk); req = 0; we = 0;
    check("R9 bit0 clear no pulse", {15'h0, shutdown}, 16'h0);
    @(negedge clk); req = 1; we = 1; addr = 6'h30; wdata = 16'h0001;
    @(negedge clk); req = 0; we = 0;
    check("R9 pulse high", {15'h0, shutdown}, 16'h1);
    @(negedge clk);
    check("R9 pulse one cycle", {15'h0, shutdown}, 16'h0);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++; n_run++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_single;
    t_multi;
    t_mask;
    t_timing;
    t_regs;
    t_power;
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule